// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM

This block is a synthesizable, cycle-accurate model of a synchronous burst static RAM of the kind that sits beside a processor on a board. Each word is made of four byte lanes. A lane is 8 bits wide, or 9 bits when a parity bit is carried. Address and control are captured on the rising clock edge. An access can be opened by either of two strobes. The processor strobe always opens a read, and a high main select blocks it. The controller strobe opens a read or a write, depending on the write controls sampled with it. Once an access is open, the next cycles with no strobe continue a four-beat burst. The burst offset either advances or holds, and its order is linear or interleaved.

Read data leaves through either a two-register pipeline or a single-register flow-through path, selected by a pin. The output-enable pin gates the drivers without waiting for a clock. The bidirectional data bus is split into `wr_data`, `rd_data` and a `rd_drive` flag. `rd_drive` high stands for drivers on. While `rd_drive` is low, `rd_data` reads zero.

The full-size part uses `ADDR_W` = 16 and `LANE_W` = 8 or 9. The defaults are smaller so that the array stays small when the design is elaborated.

Top module: `sync_burst_sram`

## Requirements
- R1: After reset, and with no access opened since, `rd_drive` is low.
- R2: The chip is selected only when `sel_main_n` = 0, `sel_hi` = 1 and `sel_lo_n` = 0. A strobe that starts an access while the chip is not selected closes any open burst and performs no access. The drivers are off in the cycle where that access's data would have appeared.
- R3: A processor strobe (`proc_strobe_n` = 0) sampled with `sel_main_n` = 1 is ignored. With `ctrl_strobe_n` = 1, an open burst continues as if no strobe were present, and a closed one stays closed.
- R4: A processor-strobe start is a read whatever the write controls are. When both strobes are low and `sel_main_n` = 0, the processor strobe wins, so the start is a read and memory is left unchanged.
- R5: A controller-strobe start is a write when `glob_wr_n` = 0, or when `lane_wr_n` = 0 with at least one `lane_sel_n` bit low. Otherwise it is a read.
- R6: With `glob_wr_n` = 0, all lanes are written. Otherwise, with `lane_wr_n` = 0, lane i (bits [i*LANE_W +: LANE_W], lane 0 = a) is written exactly when `lane_sel_n[i]` = 0. Other lanes keep their contents.
- R7: A cycle with no effective strobe continues an open burst. With `burst_adv_n` = 0, the 2-bit offset counter (reset to 0 at start) increments first. With `burst_adv_n` = 1, the same address is accessed again. Address bits [1:0] are the start's bits [1:0] plus the offset mod 4 when `burst_linear` = 1, and XOR the offset when it is 0. Higher bits are held. A continue cycle writes under the R5/R6 write controls, and otherwise reads.
- R8: With `flow_thru` = 0, read data for an address sampled at edge k is driven after edge k+1. With `flow_thru` = 1, it is driven after edge k.
- R9: When the access sampled at the latest edge is a write, `rd_drive` is low.
- R10: `out_en_n` = 1 forces `rd_drive` low combinationally, without waiting for a clock edge.
- R11: Whenever `rd_drive` is low, `rd_data` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset of control state |
| addr | input | ADDR_W | Word address sampled at a start |
| proc_strobe_n | input | 1 | Processor address strobe, active low |
| ctrl_strobe_n | input | 1 | Controller address strobe, active low |
| burst_adv_n | input | 1 | Advance the burst offset on a continue cycle, active low |
| glob_wr_n | input | 1 | Write all lanes, active low |
| lane_wr_n | input | 1 | Enable per-lane writes, active low |
| lane_sel_n | input | LANES | Per-lane write select, active low, bit 0 = lane a |
| sel_main_n | input | 1 | Main chip select, active low, gates the processor strobe |
| sel_hi | input | 1 | Chip select, active high |
| sel_lo_n | input | 1 | Chip select, active low |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| flow_thru | input | 1 | 1 = single-register flow-through, 0 = two-stage pipeline |
| burst_linear | input | 1 | 1 = linear burst order, 0 = interleaved |
| wr_data | input | LANES*LANE_W | Write data, sampled with the write access |
| rd_data | output | LANES*LANE_W | Read data, zero when not driven |
| rd_drive | output | 1 | Output drivers on |

## Verification
The bench builds the block with `ADDR_W` = 4, `LANES` = 4 and `LANE_W` = 9. With a 16-word, parity-carrying array, every address can serve as a burst start and every lane pattern can be written. This is repeated for both burst orders and both output paths. A cycle-by-cycle reference model in the bench predicts the drive flag and the data of every cycle. This covers strobe priority, select gating, suspended and advanced bursts, mid-burst deselects, and the asynchronous output enable.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
  localparam int OFS_W = 2;

  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_RD   = 2'd1,
    OP_WR   = 2'd2
  } sbs_op_e;
endpackage

// File: rtl/sbs_front.sv
module sbs_front #(
  parameter int ADDR_W = 10,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              proc_strobe_n,
  input  logic              ctrl_strobe_n,
  input  logic              burst_adv_n,
  input  logic              glob_wr_n,
  input  logic              lane_wr_n,
  input  logic [LANES-1:0]  lane_sel_n,
  input  logic              sel_main_n,
  input  logic              sel_hi,
  input  logic              sel_lo_n,
  input  logic              burst_linear,
  output logic              wr_en,
  output logic [LANES-1:0]  wr_lanes,
  output logic [ADDR_W-1:0] acc_addr,
  output logic [ADDR_W-1:0] s1_addr,
  output logic              s1_rd,
  output logic              s1_wr
);
  import sbs_pkg::*;

  logic                chip_sel, p_start, c_start;
  logic [LANES-1:0]    lanes_req;
  logic                active_q, active_d;
  logic [ADDR_W-1:0]   base_q, base_d;
  logic [OFS_W-1:0]    cnt_q, cnt_d, ofs_lo;
  sbs_op_e             op;

  assign chip_sel  = !sel_main_n && sel_hi && !sel_lo_n;
  assign p_start   = !proc_strobe_n && !sel_main_n;
  assign c_start   = !ctrl_strobe_n && !p_start;
  assign lanes_req = !glob_wr_n ? {LANES{1'b1}} : (!lane_wr_n ? ~lane_sel_n : {LANES{1'b0}});

  always_comb begin
    op       = OP_IDLE;
    active_d = active_q;
    base_d   = base_q;
    cnt_d    = cnt_q;
    ofs_lo   = '0;
    acc_addr = addr;
    if (p_start || c_start) begin
      active_d = chip_sel;
      base_d   = addr;
      cnt_d    = '0;
      if (chip_sel) op = (c_start && (|lanes_req)) ? OP_WR : OP_RD;
    end else if (active_q) begin
      cnt_d    = cnt_q + OFS_W'(!burst_adv_n);
      ofs_lo   = burst_linear ? (base_q[OFS_W-1:0] + cnt_d) : (base_q[OFS_W-1:0] ^ cnt_d);
      acc_addr = {base_q[ADDR_W-1:OFS_W], ofs_lo};
      op       = (|lanes_req) ? OP_WR : OP_RD;
    end
  end

  assign wr_en    = (op == OP_WR);
  assign wr_lanes = wr_en ? lanes_req : {LANES{1'b0}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      base_q   <= '0;
      cnt_q    <= '0;
      s1_addr  <= '0;
      s1_rd    <= 1'b0;
      s1_wr    <= 1'b0;
    end else begin
      active_q <= active_d;
      base_q   <= base_d;
      cnt_q    <= cnt_d;
      s1_addr  <= acc_addr;
      s1_rd    <= (op == OP_RD);
      s1_wr    <= (op == OP_WR);
    end
  end

  // R4: processor start on a selected chip opens a read
  a_r4_proc_start_reads: assert property (@(posedge clk) disable iff (!rst_n)
    (!proc_strobe_n && !sel_main_n && sel_hi && !sel_lo_n) |=> (s1_rd && !s1_wr));

  // R2: a start on an unselected chip performs no access
  a_r2_deselect_no_access: assert property (@(posedge clk) disable iff (!rst_n)
    ((!ctrl_strobe_n || (!proc_strobe_n && !sel_main_n)) && !(!sel_main_n && sel_hi && !sel_lo_n))
    |=> (!s1_rd && !s1_wr));

  // R3: blocked processor strobe on a closed burst does nothing
  a_r3_main_sel_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (!proc_strobe_n && sel_main_n && ctrl_strobe_n && !active_q) |=> (!s1_rd && !s1_wr));
endmodule

// File: rtl/sbs_array.sv
module sbs_array #(
  parameter int ADDR_W = 10,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    wr_en,
  input  logic [LANES-1:0]        wr_lanes,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [LANES*LANE_W-1:0] wr_data,
  input  logic [ADDR_W-1:0]       rd_addr,
  output logic [LANES*LANE_W-1:0] rd_word
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
      if (wr_en && wr_lanes[g]) mem[wr_addr] <= wr_data[g*LANE_W +: LANE_W];
    end

    assign rd_word[g*LANE_W +: LANE_W] = mem[rd_addr];
  end
endmodule

// File: rtl/sbs_outpath.sv
module sbs_outpath #(
  parameter int DATA_W = 36
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] rd_word,
  input  logic              s1_rd,
  input  logic              s1_wr,
  input  logic              flow_thru,
  input  logic              out_en_n,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_drive
);
  logic [DATA_W-1:0] s2_data;
  logic              s2_rd;
  logic              path_valid;
  logic [DATA_W-1:0] path_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_data <= '0;
      s2_rd   <= 1'b0;
    end else begin
      s2_data <= rd_word;
      s2_rd   <= s1_rd;
    end
  end

  assign path_valid = flow_thru ? s1_rd : (s2_rd && !s1_wr);
  assign path_data  = flow_thru ? rd_word : s2_data;
  assign rd_drive   = !out_en_n && path_valid;
  assign rd_data    = rd_drive ? path_data : '0;

  // R9: a write sampled at the latest edge keeps drivers off
  a_r9_write_hiz: assert property (@(posedge clk) disable iff (!rst_n)
    s1_wr |-> !rd_drive);

  // R8: pipelined read drives one edge after the access register
  a_r8_pipe_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (!flow_thru && !out_en_n && $past(s1_rd) && !s1_wr) |-> rd_drive);

  always_comb begin
    // R10: output enable high forces drivers off
    a_r10_oe_async: assert (!(out_en_n && rd_drive));
    // R11: undriven bus reads zero
    a_r11_zero_when_off: assert (rd_drive || rd_data == '0);
  end
endmodule

// File: rtl/sync_burst_sram.sv
module sync_burst_sram #(
  parameter int ADDR_W = 10,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    proc_strobe_n,
  input  logic                    ctrl_strobe_n,
  input  logic                    burst_adv_n,
  input  logic                    glob_wr_n,
  input  logic                    lane_wr_n,
  input  logic [LANES-1:0]        lane_sel_n,
  input  logic                    sel_main_n,
  input  logic                    sel_hi,
  input  logic                    sel_lo_n,
  input  logic                    out_en_n,
  input  logic                    flow_thru,
  input  logic                    burst_linear,
  input  logic [LANES*LANE_W-1:0] wr_data,
  output logic [LANES*LANE_W-1:0] rd_data,
  output logic                    rd_drive
);
  localparam int DATA_W = LANES * LANE_W;

  logic              wr_en;
  logic [LANES-1:0]  wr_lanes;
  logic [ADDR_W-1:0] acc_addr, s1_addr;
  logic              s1_rd, s1_wr;
  logic [DATA_W-1:0] rd_word;

  sbs_front #(.ADDR_W(ADDR_W), .LANES(LANES)) u_front (
    .clk(clk), .rst_n(rst_n), .addr(addr),
    .proc_strobe_n(proc_strobe_n), .ctrl_strobe_n(ctrl_strobe_n),
    .burst_adv_n(burst_adv_n), .glob_wr_n(glob_wr_n), .lane_wr_n(lane_wr_n),
    .lane_sel_n(lane_sel_n), .sel_main_n(sel_main_n), .sel_hi(sel_hi),
    .sel_lo_n(sel_lo_n), .burst_linear(burst_linear),
    .wr_en(wr_en), .wr_lanes(wr_lanes), .acc_addr(acc_addr),
    .s1_addr(s1_addr), .s1_rd(s1_rd), .s1_wr(s1_wr)
  );

  sbs_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk(clk), .wr_en(wr_en), .wr_lanes(wr_lanes), .wr_addr(acc_addr),
    .wr_data(wr_data), .rd_addr(s1_addr), .rd_word(rd_word)
  );

  sbs_outpath #(.DATA_W(DATA_W)) u_out (
    .clk(clk), .rst_n(rst_n), .rd_word(rd_word), .s1_rd(s1_rd), .s1_wr(s1_wr),
    .flow_thru(flow_thru), .out_en_n(out_en_n),
    .rd_data(rd_data), .rd_drive(rd_drive)
  );
endmodule

// File: tb/sync_burst_sram_bench.sv
module sync_burst_sram_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 4;
  localparam int NL = 4;
  localparam int LW = 9;
  localparam int DW = NL * LW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          proc_n = 1'b1, ctrl_n = 1'b1, adv_n = 1'b1;
  logic          gwe_n = 1'b1, bwe_n = 1'b1;
  logic [NL-1:0] bw_n = '1;
  logic          sel_main_n = 1'b0, sel_hi = 1'b1, sel_lo_n = 1'b0;
  logic          oe_n = 1'b0, ft = 1'b0, lin = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic          rd_drive;

  int    checks = 0;
  int    errors = 0;
  string cur_req = "R1";
  bit    done = 0;

  logic [DW-1:0] ref_mem [16];
  logic          m_active = 0;
  logic [AW-1:0] m_base = '0;
  logic [1:0]    m_cnt = '0;
  logic          prev_rd = 0;
  logic [DW-1:0] prev_val = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sync_burst_sram #(.ADDR_W(AW), .LANES(NL), .LANE_W(LW)) u_sync_burst_sram (
    .clk(clk), .rst_n(rst_n), .addr(addr), .proc_strobe_n(proc_n),
    .ctrl_strobe_n(ctrl_n), .burst_adv_n(adv_n), .glob_wr_n(gwe_n),
    .lane_wr_n(bwe_n), .lane_sel_n(bw_n), .sel_main_n(sel_main_n),
    .sel_hi(sel_hi), .sel_lo_n(sel_lo_n), .out_en_n(oe_n), .flow_thru(ft),
    .burst_linear(lin), .wr_data(wr_data), .rd_data(rd_data), .rd_drive(rd_drive)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s ft=%0d lin=%0d actual=%h expected=%h", req, ft, lin, act, exp);
    end
  endtask

  task automatic idle();
    proc_n = 1; ctrl_n = 1; adv_n = 1; gwe_n = 1; bwe_n = 1; bw_n = '1;
    sel_main_n = 0; sel_hi = 1; sel_lo_n = 0; oe_n = 0;
  endtask

  function automatic logic [DW-1:0] pat(input int a, input int s);
    logic [63:0] v;
    v = 64'(a) * 64'h0001_0203_0405_0607 ^ 64'(s) * 64'h9E37_79B9_7F4A_7C15;
    return v[DW-1:0];
  endfunction

  // One clock step with the reference model; inputs already set at a negedge.
  task automatic step();
    logic sel, p_st, c_st;
    logic [NL-1:0] lanes;
    int op;
    logic [AW-1:0] a, a_in;
    logic [1:0] cnt_n, lo;
    logic [DW-1:0] wd, cur;
    logic exp_drv;
    logic [DW-1:0] exp_dat;
    sel   = !sel_main_n && sel_hi && !sel_lo_n;
    p_st  = !proc_n && !sel_main_n;
    c_st  = !ctrl_n && !p_st;
    lanes = !gwe_n ? '1 : (!bwe_n ? ~bw_n : '0);
    op = 0; a_in = addr; a = addr; cnt_n = m_cnt; wd = wr_data;
    if (p_st || c_st) begin
      if (sel) op = (c_st && lanes != 0) ? 2 : 1;
    end else if (m_active) begin
      cnt_n = m_cnt + (adv_n ? 2'd0 : 2'd1);
      lo = lin ? (m_base[1:0] + cnt_n) : (m_base[1:0] ^ cnt_n);
      a = {m_base[AW-1:2], lo};
      op = (lanes != 0) ? 2 : 1;
    end
    @(posedge clk);
    if (p_st || c_st) begin m_active = sel; m_base = a_in; m_cnt = 0; end
    else m_cnt = cnt_n;
    if (op == 2)
      for (int i = 0; i < NL; i++) if (lanes[i]) ref_mem[a][i*LW +: LW] = wd[i*LW +: LW];
    cur = ref_mem[a];
    if (ft) begin
      exp_drv = (op == 1);
      exp_dat = cur;
    end else begin
      exp_drv = prev_rd && (op != 2);
      exp_dat = prev_val;
    end
    prev_rd = (op == 1);
    prev_val = cur;
    exp_drv = exp_drv && !oe_n;
    if (!exp_drv) exp_dat = '0;
    @(negedge clk);
    chk(rd_drive == exp_drv, cur_req, 64'(rd_drive), 64'(exp_drv));
    chk(rd_data == exp_dat, cur_req, 64'(rd_data), 64'(exp_dat));
  endtask

  task automatic read_burst(input int b, input bit dirty_we);
    idle(); proc_n = 0; addr = AW'(b);
    if (dirty_we) begin gwe_n = 0; wr_data = '1; end
    step();
    idle();
    for (int k = 0; k < 3; k++) begin adv_n = 0; step(); end
    adv_n = 1; step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) ref_mem[i] = '0;
    idle();
    repeat (3) @(negedge clk);
    cur_req = "R1";
    chk(rd_drive == 1'b0, "R1 reset", 64'(rd_drive), 64'd0);
    chk(rd_data == '0, "R1 R11 reset", 64'(rd_data), 64'd0);
    rst_n = 1;
    @(negedge clk);
    chk(rd_drive == 1'b0, "R1 after release", 64'(rd_drive), 64'd0);

    for (int cfg = 0; cfg < 4; cfg++) begin
      ft = cfg[0]; lin = cfg[1];
      idle(); step();
      // R5 R6: global write fill through controller strobe
      cur_req = "R5 R6 global write";
      for (int a = 0; a < 16; a++) begin
        idle(); ctrl_n = 0; gwe_n = 0; addr = AW'(a); wr_data = pat(a, cfg); step();
      end
      // R7 R8: processor read bursts from every start, R4 write controls ignored
      cur_req = "R4 R7 R8 read burst";
      for (int b = 0; b < 16; b++) read_burst(b, b[0]);
      // R6 R7 R9: lane write bursts via controller strobe
      cur_req = "R6 R7 R9 lane write burst";
      for (int b = 1; b < 16; b += 5) begin
        idle(); ctrl_n = 0; bwe_n = 0; addr = AW'(b);
        bw_n = ~(NL'(1) << (b % NL)); wr_data = pat(b, 40 + cfg); step();
        for (int k = 0; k < 3; k++) begin
          idle(); adv_n = 0; bwe_n = 0; bw_n = NL'(k + 5 + b); wr_data = pat(k, 80 + b); step();
        end
        idle(); step();
        read_burst(b, 0);
      end
      // R4: both strobes low, selected: read wins, nothing written
      cur_req = "R4 both strobes";
      idle(); proc_n = 0; ctrl_n = 0; gwe_n = 0; addr = 4'd6; wr_data = '0; step();
      idle(); step();
      read_burst(6, 0);
      // R2: deselect through controller strobe mid burst
      cur_req = "R2 deselect";
      idle(); proc_n = 0; addr = 4'd9; step();
      idle(); ctrl_n = 0; sel_hi = 0; step();
      idle(); adv_n = 0; step();
      idle(); ctrl_n = 0; sel_lo_n = 1; gwe_n = 0; addr = 4'd9; wr_data = '0; step();
      idle(); step();
      // R3: blocked processor strobe on a closed burst, then mid burst
      cur_req = "R3 main select blocks";
      idle(); proc_n = 0; sel_main_n = 1; addr = 4'd3; step();
      idle(); step();
      idle(); proc_n = 0; addr = 4'd12; step();
      idle(); proc_n = 0; sel_main_n = 1; adv_n = 0; addr = 4'd0; step();
      idle(); adv_n = 0; step();
      idle(); step();
      // R2: controller strobe with main select high is a deselect
      cur_req = "R2 R3 ctrl with main high";
      idle(); ctrl_n = 0; sel_main_n = 1; gwe_n = 0; addr = 4'd1; wr_data = '0; step();
      idle(); step();
      read_burst(1, 0);
      // R10 R11: asynchronous output enable
      cur_req = "R10 R11 oe";
      idle(); proc_n = 0; addr = 4'd5; step();
      idle(); step();
      oe_n = 1; #1;
      chk(rd_drive == 1'b0, "R10 oe high", 64'(rd_drive), 64'd0);
      chk(rd_data == '0, "R11 oe high", 64'(rd_data), 64'd0);
      oe_n = 0; #1;
      chk(rd_drive == 1'b1, "R10 oe low again", 64'(rd_drive), 64'd1);
      chk(rd_data == ref_mem[ft ? 5 : 5], "R10 data back", 64'(rd_data), 64'(ref_mem[5]));
      idle(); ctrl_n = 0; sel_hi = 0; step();
      idle(); step();
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule